// File: doc/BRIEF.md
# Bitslip Best Window Selector

This block picks the bitslip setting that gives one data lane the widest usable read window. When started, it sweeps every bitslip position in turn. At each position it asks an external scan engine for a quality score and then has a delay-centering controller re-centre the lane. While sweeping, it keeps a running record of the position with the highest score.

The PHY's bitslip can only be cleared or moved forward by one step. After the sweep the block therefore clears the bitslip and steps it forward until it reaches the winning position. It then raises a done flag and publishes the chosen index.

Both collaborators use simple pulse handshakes. A one-cycle request is answered some cycles later by a one-cycle response. The block waits for each response and needs no bound on its latency.

Top module: `bslip_best_sel`

## Requirements
- R1: A start pulse accepted while idle or done produces a one-cycle `slip_rst_o` pulse before the first `score_req_o` of the sweep.
- R2: Bitslip positions 0 to BITSLIPS-1 are visited in ascending order. Each position gets exactly one score request, then exactly one centering start. The centering start is issued only in the cycle after a `score_vld_i` response. The sweep moves on only after `ctr_done_i`.
- R3: The best score and best index both start at 0. A new score replaces the best only if it is strictly greater (unsigned), so on a tie the lowest index is kept, and an all-zero sweep selects index 0.
- R4: During the sweep exactly BITSLIPS-1 `slip_inc_o` pulses are issued, one between each pair of adjacent positions. None is issued after the last position.
- R5: After the last centering completes, one `slip_rst_o` pulse is issued, followed by exactly best-index `slip_inc_o` pulses on consecutive cycles. After that, `done_o` rises.
- R6: Once `done_o` is high it stays high, with `best_idx_o` stable and no pulse on `slip_rst_o`, `slip_inc_o`, `score_req_o` or `ctr_start_o`, until the next start.
- R7: At most one of `slip_rst_o`, `slip_inc_o`, `score_req_o` and `ctr_start_o` is high in any cycle.
- R8: While synchronous reset is high, all outputs are 0. After reset the block is idle, with `done_o` low and `best_idx_o` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a selection run (accepted when idle or done) |
| slip_rst_o | output | 1 | Pulse: clear the lane bitslip to 0 |
| slip_inc_o | output | 1 | Pulse: advance the lane bitslip by one |
| score_req_o | output | 1 | Pulse: request a score for the current bitslip |
| score_vld_i | input | 1 | Pulse: score response valid |
| score_i | input | SCORE_W | Unsigned score, sampled with `score_vld_i` |
| ctr_start_o | output | 1 | Pulse: start a delay-centering pass |
| ctr_done_i | input | 1 | Pulse: centering pass finished |
| done_o | output | 1 | Selection complete; held until next start |
| best_idx_o | output | $clog2(BITSLIPS) | Selected bitslip index |

## Verification
A wrong best-score or best-index register does not show until the final replay. It then appears as the wrong number of step pulses after the second clear and as a wrong `best_idx_o`, one sweep after the fault. A damaged sweep counter shows at once as an out-of-order score request, a missing or extra step pulse, or an early or late start of the replay. The bench models the PHY bitslip from the clear and step pulses. It compares every visited position, and the final lane position, against an argmax it computes itself.

// File: rtl/bsel_pkg.sv
package bsel_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLR,
        S_ASK,
        S_WAIT_SCORE,
        S_CENTER,
        S_WAIT_CENTER,
        S_STEP_SCAN,
        S_CLR_FINAL,
        S_REPLAY,
        S_DONE
    } bsel_state_e;

    typedef struct packed {
        logic slip_rst;
        logic slip_inc;
        logic score_req;
        logic ctr_start;
        logic done;
    } bsel_cmd_t;

    // Moore decode of the fixed pulses; replay steps are added by the FSM.
    function automatic bsel_cmd_t cmd_of(bsel_state_e s);
        bsel_cmd_t c;
        c = '0;
        case (s)
            S_CLR, S_CLR_FINAL: c.slip_rst  = 1'b1;
            S_STEP_SCAN:        c.slip_inc  = 1'b1;
            S_ASK:              c.score_req = 1'b1;
            S_CENTER:           c.ctr_start = 1'b1;
            S_DONE:             c.done      = 1'b1;
            default:            c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bsel_idx_counter.sv
module bsel_idx_counter #(
    parameter int W   = 3,
    parameter int MAX = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] LIMIT = W'(MAX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    // R4: the counter is never advanced past its last position
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |-> (count != LIMIT));

endmodule

// File: rtl/bsel_best_tracker.sv
module bsel_best_tracker #(
    parameter int SW = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          load,
    input  logic [SW-1:0] cand_score,
    input  logic [IW-1:0] cand_idx,
    output logic [IW-1:0] best_idx
);
    logic [SW-1:0] best_score;
    logic          beats;

    assign beats = cand_score > best_score;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            best_score <= '0;
            best_idx   <= '0;
        end else if (load && beats) begin
            best_score <= cand_score;
            best_idx   <= cand_idx;
        end
    end

    // R3: within a sweep the recorded best score never decreases
    p_best_mono_r3: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (best_score >= $past(best_score)));

    // R3: a score that does not beat the best leaves the index unchanged
    p_tie_keeps_r3: assert property (@(posedge clk) disable iff (rst)
        (load && !clr && cand_score <= best_score) |=> $stable(best_idx));

endmodule

// File: rtl/bsel_fsm.sv
module bsel_fsm
    import bsel_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          score_vld,
    input  logic          ctr_done,
    input  logic          scan_last,
    input  logic [IW-1:0] step_idx,
    input  logic [IW-1:0] best_idx,
    output bsel_cmd_t     cmd,
    output logic          trk_clr,
    output logic          trk_load,
    output logic          scan_clr,
    output logic          scan_inc,
    output logic          step_clr,
    output logic          step_inc
);
    bsel_state_e state, nxt;
    logic        accept;
    logic        replay_more;

    assign accept      = start && (state == S_IDLE || state == S_DONE);
    assign replay_more = (state == S_REPLAY) && (step_idx != best_idx);

    always_comb begin
        nxt = state;
        case (state)
            S_IDLE, S_DONE: if (start)     nxt = S_CLR;
            S_CLR:                         nxt = S_ASK;
            S_ASK:                         nxt = S_WAIT_SCORE;
            S_WAIT_SCORE:  if (score_vld)  nxt = S_CENTER;
            S_CENTER:                      nxt = S_WAIT_CENTER;
            S_WAIT_CENTER: if (ctr_done)   nxt = scan_last ? S_CLR_FINAL : S_STEP_SCAN;
            S_STEP_SCAN:                   nxt = S_ASK;
            S_CLR_FINAL:                   nxt = S_REPLAY;
            S_REPLAY:      if (!replay_more) nxt = S_DONE;
            default:                       nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        cmd          = cmd_of(state);
        cmd.slip_inc = cmd.slip_inc | replay_more;
    end

    assign trk_clr  = accept;
    assign trk_load = (state == S_WAIT_SCORE) && score_vld;
    assign scan_clr = accept;
    assign scan_inc = (state == S_STEP_SCAN);
    assign step_clr = (state == S_CLR_FINAL);
    assign step_inc = replay_more;

    // R7: lane commands never overlap
    p_one_cmd_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.slip_rst, cmd.slip_inc, cmd.score_req, cmd.ctr_start}));

    // R2: centering is launched only right after a score response
    p_ctr_after_score_r2: assert property (@(posedge clk) disable iff (rst)
        cmd.ctr_start |-> $past(score_vld));

endmodule

// File: rtl/bslip_best_sel.sv
module bslip_best_sel #(
    parameter int BITSLIPS = 8,
    parameter int SCORE_W  = 8,
    localparam int IDX_W   = (BITSLIPS > 2) ? $clog2(BITSLIPS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    output logic               slip_rst_o,
    output logic               slip_inc_o,
    output logic               score_req_o,
    input  logic               score_vld_i,
    input  logic [SCORE_W-1:0] score_i,
    output logic               ctr_start_o,
    input  logic               ctr_done_i,
    output logic               done_o,
    output logic [IDX_W-1:0]   best_idx_o
);
    import bsel_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BITSLIPS - 1);

    bsel_cmd_t        cmd;
    logic             trk_clr, trk_load;
    logic             scan_clr, scan_inc, step_clr, step_inc;
    logic [IDX_W-1:0] scan_idx, step_idx, best_idx;

    bsel_fsm #(.IW(IDX_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .score_vld (score_vld_i),
        .ctr_done  (ctr_done_i),
        .scan_last (scan_idx == LAST_IDX),
        .step_idx  (step_idx),
        .best_idx  (best_idx),
        .cmd       (cmd),
        .trk_clr   (trk_clr),
        .trk_load  (trk_load),
        .scan_clr  (scan_clr),
        .scan_inc  (scan_inc),
        .step_clr  (step_clr),
        .step_inc  (step_inc)
    );

    bsel_idx_counter #(.W(IDX_W), .MAX(BITSLIPS - 1)) u_scan_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (scan_clr),
        .inc   (scan_inc),
        .count (scan_idx)
    );

    bsel_idx_counter #(.W(IDX_W), .MAX(BITSLIPS - 1)) u_step_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (step_clr),
        .inc   (step_inc),
        .count (step_idx)
    );

    bsel_best_tracker #(.SW(SCORE_W), .IW(IDX_W)) u_tracker (
        .clk        (clk),
        .rst        (rst),
        .clr        (trk_clr),
        .load       (trk_load),
        .cand_score (score_i),
        .cand_idx   (scan_idx),
        .best_idx   (best_idx)
    );

    assign slip_rst_o  = cmd.slip_rst;
    assign slip_inc_o  = cmd.slip_inc;
    assign score_req_o = cmd.score_req;
    assign ctr_start_o = cmd.ctr_start;
    assign done_o      = cmd.done;
    assign best_idx_o  = best_idx;

    // R6: the published index holds while done stays high
    p_idx_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (done_o && $past(done_o)) |-> $stable(best_idx_o));

    // R6: done only falls in response to a new start
    p_done_held_r6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> done_o);

endmodule

// File: tb/bslip_best_sel_bench.sv
module bslip_best_sel_bench;
    localparam int N  = 8;
    localparam int SW = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          score_vld_i = 1'b0;
    logic [SW-1:0] score_i = '0;
    logic          ctr_done_i = 1'b0;
    logic          slip_rst_o, slip_inc_o, score_req_o, ctr_start_o, done_o;
    logic [IW-1:0] best_idx_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // bench model of the lane and the collaborators
    logic [SW-1:0] tbl [N];
    int phy, clr_cnt, scan_inc, fin_inc, nreq, nctr, sdel, cdel;
    int visited [16];
    int ctr_at  [16];

    always #2 clk = ~clk;

    bslip_best_sel #(.BITSLIPS(N), .SCORE_W(SW)) u_bslip_best_sel (
        .clk(clk), .rst(rst), .start_i(start_i),
        .slip_rst_o(slip_rst_o), .slip_inc_o(slip_inc_o),
        .score_req_o(score_req_o), .score_vld_i(score_vld_i), .score_i(score_i),
        .ctr_start_o(ctr_start_o), .ctr_done_i(ctr_done_i),
        .done_o(done_o), .best_idx_o(best_idx_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        clr_cnt = 0; scan_inc = 0; fin_inc = 0; nreq = 0; nctr = 0;
        for (int i = 0; i < 16; i++) begin visited[i] = -1; ctr_at[i] = -1; end
    endtask

    initial begin
        phy = 0; sdel = 0; cdel = 0;
        clear_model();
        forever begin
            @(negedge clk);
            score_vld_i = 1'b0;
            ctr_done_i  = 1'b0;
            if (sdel > 0) begin
                sdel--;
                if (sdel == 0) begin score_vld_i = 1'b1; score_i = tbl[phy % N]; end
            end
            if (cdel > 0) begin
                cdel--;
                if (cdel == 0) ctr_done_i = 1'b1;
            end
            if (!rst) begin
                if (slip_rst_o) begin phy = 0; clr_cnt++; end
                if (slip_inc_o) begin
                    phy++;
                    if (clr_cnt == 1) scan_inc++; else fin_inc++;
                end
                if (score_req_o) begin
                    if (nreq < 16) visited[nreq] = (clr_cnt == 0) ? -2 : phy;
                    nreq++; sdel = 3;
                end
                if (ctr_start_o) begin
                    if (nctr < 16) ctr_at[nctr] = phy;
                    nctr++; cdel = 2;
                end
            end
        end
    end

    // pattern: byte i holds the score of bitslip i
    task automatic run_case(input string name, input logic [8*N-1:0] pat);
        int exp_idx, exp_sc, guard;
        bit order_ok;
        for (int i = 0; i < N; i++) tbl[i] = pat[8*i +: 8];
        exp_idx = 0; exp_sc = 0;
        for (int i = 0; i < N; i++)
            if (int'(tbl[i]) > exp_sc) begin exp_sc = tbl[i]; exp_idx = i; end
        @(negedge clk);
        clear_model();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!done_o, {name, " R6 done drops on start"}, done_o, 0);
        guard = 0;
        while (!done_o && guard < 2000) begin @(negedge clk); guard++; end
        chk(guard < 2000, {name, " R5 done reached"}, guard, 0);
        order_ok = 1'b1;
        for (int i = 0; i < N; i++)
            if (visited[i] != i || ctr_at[i] != i) order_ok = 1'b0;
        chk(order_ok, {name, " R2 ascending visit order"}, visited[N-1], N-1);
        chk(visited[0] == 0, {name, " R1 clear before first request"}, visited[0], 0);
        chk(nreq == N && nctr == N, {name, " R2 one request and centering each"}, nreq*100+nctr, N*100+N);
        chk(scan_inc == N-1, {name, " R4 sweep increments"}, scan_inc, N-1);
        chk(clr_cnt == 2, {name, " R5 two clears"}, clr_cnt, 2);
        chk(fin_inc == exp_idx, {name, " R5 replay increments"}, fin_inc, exp_idx);
        chk(best_idx_o == exp_idx, {name, " R3 selected index"}, best_idx_o, exp_idx);
        chk(phy == exp_idx, {name, " R5 lane left at best"}, phy, exp_idx);
    endtask

    task automatic hold_case();
        int idx0, p0, c0, f0, r0;
        bit ok;
        idx0 = best_idx_o; p0 = phy; c0 = clr_cnt; f0 = fin_inc; r0 = nreq;
        ok = 1'b1;
        repeat (25) begin
            @(negedge clk);
            if (!done_o || best_idx_o != idx0) ok = 1'b0;
        end
        chk(ok, "R6 done and index held", best_idx_o, idx0);
        chk(phy == p0 && clr_cnt == c0 && fin_inc == f0 && nreq == r0,
            "R6 no lane activity while done", phy, p0);
    endtask

    task automatic reset_case();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk({slip_rst_o, slip_inc_o, score_req_o, ctr_start_o, done_o} == 5'b0,
            "R8 outputs low in reset", {slip_rst_o, slip_inc_o, score_req_o, ctr_start_o, done_o}, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(!done_o, "R8 idle after reset", done_o, 0);
        chk(best_idx_o == 0, "R8 index zero after reset", best_idx_o, 0);
        chk(!slip_rst_o && !score_req_o, "R1 no activity without start", slip_rst_o, 0);
    endtask

    initial begin
        reset_case();
        run_case("peak5",  64'h05_40_C8_10_30_20_00_10);
        hold_case();
        run_case("tie",    64'h10_90_00_00_00_90_10_01);  // R3 ties at 2 and 6 -> 2
        run_case("zeros",  64'h00_00_00_00_00_00_00_00);  // R3 all zero -> 0
        run_case("last",   64'hFF_FE_10_10_10_10_10_10);  // R5 seven replay steps
        run_case("first",  64'h01_02_03_04_05_06_07_FF);  // R4 first wins
        hold_case();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule